// File: doc/BRIEF.md
# AC-link output frame generator

This block produces the outgoing serial stream of an AC-link audio link. It counts bit clocks and builds one 256-bit frame at a time: a 16-bit tag slot, then twelve 20-bit slots. The frame goes out on `sdata_out` MSB first, one bit per bit clock. `sync` is high for the tag slot. At the fixed 48 kHz frame rate the bit clock runs at 12.288 MHz.

A requester hands in one codec register access. It gives the direction, a 7-bit register index, 16 bits of write data and the target codec, primary or secondary. An access to an odd index is refused at once. An even access is held until the next frame boundary and acknowledged in the first bit clock of the frame that carries it. The block fills the tag from what the frame carries: the frame-valid flag, the per-slot valid flags and the codec ID field. A left/right PCM pair, optionally mono, can ride in slots 3 and 4.

The block also watches the incoming serial lines of both codecs. It latches each codec's ready flag from the first bit of the incoming tag. Each flag is taken once and is then frozen until a power-state change strobe re-arms it.

Top module: `aclink_out_gen`

## Requirements
- R1: While reset is asserted, `sync`, `sdata_out`, `ready_pri` and `ready_sec` are low and `cmd_ready` is high.
- R2: Frames repeat every 256 bit clocks. `sync` is high for exactly the first 16 bit clocks of each frame. Bit 15 of the tag goes out first, then slots 1 to 12, each MSB first.
- R3: Tag bit 15 (frame valid) is 1 exactly when the frame carries a command or PCM data. Every slot bit and tag bit not given a meaning below is 0, so a frame with nothing to carry is all zeros.
- R4: A primary-codec command sets tag bits 14 and 13 (slot 1 and slot 2 valid) and leaves the codec ID, tag bits 1:0, at 00.
- R5: A secondary-codec command clears tag bits 14 and 13, sets tag bit 15, and puts the parameter `SEC_ID` in tag bits 1:0.
- R6: Slot 1 bit 19 is 1 for a read and 0 for a write. Slot 1 bits 18:12 hold the register index. Slot 1 bits 11:0 are 0.
- R7: For a write, slot 2 bits 19:4 carry the write data and bits 3:0 are 0. For a read, slot 2 is all zero.
- R8: A request with an odd index (bit 0 set) is refused. `cmd_reject` pulses for one cycle after the request, `cmd_ready` stays high, and no frame carries the access.
- R9: An accepted request drops `cmd_ready` until its frame begins. `cmd_ack` pulses once, in the first bit clock of that frame, and the frame carries the access.
- R10: With `pcm_valid`, tag bits 12 and 11 are set, slot 3 carries `pcm_left` and slot 4 carries `pcm_right`, or `pcm_left` when `pcm_mono` is set. The PCM inputs are sampled at the frame boundary.
- R11: Each codec's ready output takes the value of its input line in the first bit clock of a frame, once. Values in later frames, and in other bit positions, have no effect.
- R12: A `pwr_change` pulse re-arms both ready flags, and the next frame's first incoming bit is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Register access request strobe |
| cmd_write | input | 1 | 1 = write access, 0 = read access |
| cmd_index | input | 7 | Codec register index (must be even) |
| cmd_wdata | input | 16 | Data for a write access |
| cmd_secondary | input | 1 | 1 = secondary codec, 0 = primary |
| cmd_ready | output | 1 | High when a new request can be taken |
| cmd_ack | output | 1 | Pulse: the held access starts its frame |
| cmd_reject | output | 1 | Pulse: request refused for odd index |
| pcm_valid | input | 1 | Send the PCM pair in the next frame |
| pcm_mono | input | 1 | Copy the left sample into the right slot |
| pcm_left | input | 20 | Left sample |
| pcm_right | input | 20 | Right sample |
| pwr_change | input | 1 | Power-state change strobe, re-arms ready capture |
| sdata_in_pri | input | 1 | Serial input from the primary codec |
| sdata_in_sec | input | 1 | Serial input from the secondary codec |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdata_out | output | 1 | Serial frame output |
| ready_pri | output | 1 | Latched primary codec ready |
| ready_sec | output | 1 | Latched secondary codec ready |

## Verification
The bench sweeps every even register index, alternating direction, codec and PCM mode, and compares each field of the captured frame.

- A tag builder that confused the two codec cases would put slot valid bits in a secondary frame, or a nonzero ID in a primary one.
- A slot packer off by one position would shift the index or the data into bits that must be zero.
- Odd indices are offered to catch a design that queues them; such a design would produce a nonzero frame and an acknowledge.
- The ready tests drive one value in the first tag bit and the opposite value in every other bit. A latch that sampled late, or that kept sampling every frame, shows the wrong level.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int FRAME_W    = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_W);
  localparam int IDX_W      = 7;
  localparam int DAT_W      = 16;
  localparam int PCM_W      = SLOT_W;
  localparam int ID_W       = 2;
  localparam int NUM_CODECS = 2;

  typedef struct packed {
    logic             write;
    logic [IDX_W-1:0] index;
    logic [DAT_W-1:0] wdata;
    logic             secondary;
  } reg_cmd_t;
endpackage

// File: rtl/aclk_rst_sync.sv
module aclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer
  import aclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic load,
  output logic first_bit,
  output logic sync
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q, sync_d;

  // Bit counter: the last position triggers the parallel load of the next frame.
  always_comb begin
    load      = (cnt_q == CNT_W'(FRAME_W - 1));
    first_bit = (cnt_q == '0);
    cnt_d     = load ? '0 : cnt_q + CNT_W'(1);
    sync_d    = (cnt_d < CNT_W'(TAG_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(FRAME_W - 1);
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign sync = sync_q;
endmodule

// File: rtl/aclk_cmd_hold.sv
module aclk_cmd_hold
  import aclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  reg_cmd_t req_cmd,
  input  logic     load,
  output logic     req_ready,
  output logic     req_ack,
  output logic     req_reject,
  output logic     held_on,
  output reg_cmd_t held_cmd
);
  logic     pend_q, pend_d;
  logic     ack_q, ack_d;
  logic     rej_q, rej_d;
  logic     take, odd;
  reg_cmd_t cmd_q;

  always_comb begin
    odd    = req_cmd.index[0];
    take   = req_valid && !pend_q && !odd;
    rej_d  = req_valid && !pend_q && odd;
    ack_d  = load && pend_q;
    pend_d = pend_q;
    if (take)      pend_d = 1'b1;
    else if (load) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ack_q  <= ack_d;
      rej_q  <= rej_d;
    end
  end

  // Payload register with explicit enable; no reset needed on data.
  always_ff @(posedge clk) begin
    if (take) cmd_q <= req_cmd;
  end

  assign req_ready  = !pend_q;
  assign req_ack    = ack_q;
  assign req_reject = rej_q;
  assign held_on    = pend_q;
  assign held_cmd   = cmd_q;
endmodule

// File: rtl/aclk_frame_build.sv
module aclk_frame_build
  import aclk_pkg::*;
#(
  parameter logic [ID_W-1:0] SEC_ID = 2'b01
) (
  input  logic               cmd_on,
  input  reg_cmd_t           cmd,
  input  logic               pcm_on,
  input  logic               pcm_mono,
  input  logic [PCM_W-1:0]   pcm_l,
  input  logic [PCM_W-1:0]   pcm_r,
  output logic [FRAME_W-1:0] frame
);
  // Tag bit positions: frame flag at the top, slot n valid at TAG_W-1-n.
  localparam int FLAG_B = TAG_W - 1;
  localparam int V_S1   = TAG_W - 2;
  localparam int V_S2   = TAG_W - 3;
  localparam int V_S3   = TAG_W - 4;
  localparam int V_S4   = TAG_W - 5;

  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] slot [NUM_SLOTS];

  always_comb begin
    tag = '0;
    for (int s = 0; s < NUM_SLOTS; s++) slot[s] = '0;
    if (cmd_on) begin
      slot[0] = {~cmd.write, cmd.index, {(SLOT_W-1-IDX_W){1'b0}}};
      if (cmd.write) slot[1] = {cmd.wdata, {(SLOT_W-DAT_W){1'b0}}};
      if (cmd.secondary) begin
        tag[ID_W-1:0] = SEC_ID;
      end else begin
        tag[V_S1] = 1'b1;
        tag[V_S2] = 1'b1;
      end
    end
    if (pcm_on) begin
      slot[2]   = pcm_l;
      slot[3]   = pcm_mono ? pcm_l : pcm_r;
      tag[V_S3] = 1'b1;
      tag[V_S4] = 1'b1;
    end
    tag[FLAG_B] = cmd_on || pcm_on;
  end

  assign frame[FRAME_W-1 -: TAG_W] = tag;
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_place
    assign frame[FRAME_W-TAG_W-1-s*SLOT_W -: SLOT_W] = slot[s];
  end
endmodule

// File: rtl/aclk_serializer.sv
module aclk_serializer
  import aclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdata
);
  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = load ? frame_in : {sh_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sdata = sh_q[FRAME_W-1];
endmodule

// File: rtl/aclk_ready_latch.sv
module aclk_ready_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic first_bit,
  input  logic rearm,
  input  logic sdin,
  output logic ready
);
  logic armed_q, armed_d;
  logic rdy_q, rdy_d;

  always_comb begin
    armed_d = armed_q;
    rdy_d   = rdy_q;
    if (first_bit && armed_q) begin
      rdy_d   = sdin;
      armed_d = 1'b0;
    end
    if (rearm) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      rdy_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      rdy_q   <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/aclink_out_gen.sv
module aclink_out_gen
  import aclk_pkg::*;
#(
  parameter logic [ID_W-1:0] SEC_ID = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [DAT_W-1:0] cmd_wdata,
  input  logic             cmd_secondary,
  output logic             cmd_ready,
  output logic             cmd_ack,
  output logic             cmd_reject,
  input  logic             pcm_valid,
  input  logic             pcm_mono,
  input  logic [PCM_W-1:0] pcm_left,
  input  logic [PCM_W-1:0] pcm_right,
  input  logic             pwr_change,
  input  logic             sdata_in_pri,
  input  logic             sdata_in_sec,
  output logic             sync,
  output logic             sdata_out,
  output logic             ready_pri,
  output logic             ready_sec
);
  logic               rst_q_n;
  logic               load, first_bit;
  logic               held_on;
  reg_cmd_t           req_cmd, held_cmd;
  logic [FRAME_W-1:0] frame;
  logic [NUM_CODECS-1:0] sdin_vec, rdy_vec;

  assign req_cmd = '{write: cmd_write, index: cmd_index, wdata: cmd_wdata,
                     secondary: cmd_secondary};

  aclk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(rst_q_n)
  );

  aclk_frame_timer u_timer (
    .clk(clk), .rst_n(rst_q_n), .load(load), .first_bit(first_bit), .sync(sync)
  );

  aclk_cmd_hold u_hold (
    .clk(clk), .rst_n(rst_q_n), .req_valid(cmd_valid), .req_cmd(req_cmd),
    .load(load), .req_ready(cmd_ready), .req_ack(cmd_ack),
    .req_reject(cmd_reject), .held_on(held_on), .held_cmd(held_cmd)
  );

  aclk_frame_build #(.SEC_ID(SEC_ID)) u_build (
    .cmd_on(held_on), .cmd(held_cmd), .pcm_on(pcm_valid), .pcm_mono(pcm_mono),
    .pcm_l(pcm_left), .pcm_r(pcm_right), .frame(frame)
  );

  aclk_serializer u_ser (
    .clk(clk), .rst_n(rst_q_n), .load(load), .frame_in(frame), .sdata(sdata_out)
  );

  assign sdin_vec = {sdata_in_sec, sdata_in_pri};
  for (genvar c = 0; c < NUM_CODECS; c++) begin : g_rdy
    aclk_ready_latch u_lat (
      .clk(clk), .rst_n(rst_q_n), .first_bit(first_bit), .rearm(pwr_change),
      .sdin(sdin_vec[c]), .ready(rdy_vec[c])
    );
  end
  assign ready_pri = rdy_vec[0];
  assign ready_sec = rdy_vec[1];
endmodule

// File: rtl/aclink_out_gen_chk.sv
module aclink_out_gen_chk
  import aclk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sync,
  input logic cmd_ready,
  input logic cmd_ack,
  input logic cmd_reject,
  input logic ready_pri,
  input logic ready_sec
);
  logic [5:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_len <= '0;
    else if (sync) hi_len <= hi_len + 6'd1;
    else           hi_len <= '0;
  end

  // R2: sync never stays high longer than the tag slot
  a_r2_sync_max: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> hi_len < 6'(TAG_W));

  // R2: a sync pulse, once ended, lasted the whole tag slot
  a_r2_sync_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && hi_len != 0) |-> hi_len == 6'(TAG_W));

  // R9: acknowledge only in the first bit clock of a frame
  a_r9_ack_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $rose(sync));

  // R9: acknowledge only for a request that was being held
  a_r9_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> !$past(cmd_ready));

  // R8: a refused request leaves the requester side free
  a_r8_reject_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> cmd_ready && !cmd_ack);

  // R11: ready flags move only right after the first tag bit
  a_r11_pri_when: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ready_pri) |-> $past(sync) && !$past(sync, 2));

  a_r11_sec_when: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ready_sec) |-> $past(sync) && !$past(sync, 2));
endmodule

bind aclink_out_gen aclink_out_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .cmd_ready(cmd_ready),
  .cmd_ack(cmd_ack), .cmd_reject(cmd_reject),
  .ready_pri(ready_pri), .ready_sec(ready_sec)
);

// File: tb/test_aclink_out_gen.sv
`timescale 1ns/1ps
module test_aclink_out_gen;
  localparam logic [1:0] SEC = 2'b01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_write, cmd_secondary;
  logic [6:0]  cmd_index;
  logic [15:0] cmd_wdata;
  logic        cmd_ready, cmd_ack, cmd_reject;
  logic        pcm_valid, pcm_mono;
  logic [19:0] pcm_left, pcm_right;
  logic        pwr_change, sdata_in_pri, sdata_in_sec;
  logic        sync, sdata_out, ready_pri, ready_sec;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  aclink_out_gen #(.SEC_ID(SEC)) i_aclink_out_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_index(cmd_index), .cmd_wdata(cmd_wdata), .cmd_secondary(cmd_secondary),
    .cmd_ready(cmd_ready), .cmd_ack(cmd_ack), .cmd_reject(cmd_reject),
    .pcm_valid(pcm_valid), .pcm_mono(pcm_mono), .pcm_left(pcm_left),
    .pcm_right(pcm_right), .pwr_change(pwr_change), .sdata_in_pri(sdata_in_pri),
    .sdata_in_sec(sdata_in_sec), .sync(sync), .sdata_out(sdata_out),
    .ready_pri(ready_pri), .ready_sec(ready_sec)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected frame, built from the requirement text.
  function automatic logic [255:0] exp_frame(bit has_cmd, bit wr, bit [6:0] idx,
      bit [15:0] d, bit sec, bit pv, bit pm, bit [19:0] l, bit [19:0] r);
    logic [255:0] f;
    f = '0;
    if (has_cmd) begin
      f[255] = 1'b1;
      if (sec) f[241:240] = SEC;
      else begin f[254] = 1'b1; f[253] = 1'b1; end
      f[239]     = !wr;
      f[238:232] = idx;
      if (wr) f[219:204] = d;
    end
    if (pv) begin
      f[255] = 1'b1; f[252] = 1'b1; f[251] = 1'b1;
      f[199:180] = l;
      f[179:160] = pm ? l : r;
    end
    return f;
  endfunction

  // Returns at the first falling edge where sync has just gone high.
  task automatic wait_start();
    logic p;
    p = sync;
    forever begin
      @(negedge clk);
      if (sync && !p) break;
      p = sync;
    end
  endtask

  // Called at a frame-start falling edge; gathers 256 bits.
  task automatic capture(output logic [255:0] f, output int bad_sync, output int acks);
    bad_sync = 0;
    acks = 0;
    for (int i = 0; i < 256; i++) begin
      if (i != 0) @(negedge clk);
      f[255-i] = sdata_out;
      if (sync !== (i < 16)) bad_sync++;
      if (cmd_ack) acks++;
    end
  endtask

  task automatic run_cmd(bit wr, bit [6:0] idx, bit [15:0] d, bit sec);
    logic [255:0] f, e;
    int bs, ak;
    bit odd;
    odd = idx[0];
    wait_start();
    cmd_valid = 1'b1; cmd_write = wr; cmd_index = idx;
    cmd_wdata = d; cmd_secondary = sec;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (odd) chk("R8 reject pulse and ready", 256'({cmd_reject, cmd_ready}), 256'(2'b11));
    else     chk("R9 ready low while held", 256'({cmd_reject, cmd_ready}), 256'(2'b00));
    wait_start();
    capture(f, bs, ak);
    e = exp_frame(!odd, wr, idx, d, sec, pcm_valid, pcm_mono, pcm_left, pcm_right);
    chk("R2 sync shape", 256'(bs), 256'(0));
    chk(odd ? "R8 ack count" : "R9 ack count", 256'(ak), 256'(odd ? 0 : 1));
    if (odd) chk("R8 no access in frame", f, e);
    else begin
      chk(sec ? "R5 R3 tag" : "R4 R3 tag", 256'(f[255:240]), 256'(e[255:240]));
      chk("R6 slot1", 256'(f[239:220]), 256'(e[239:220]));
      chk("R7 slot2", 256'(f[219:200]), 256'(e[219:200]));
      chk("R10 pcm slots", 256'(f[199:160]), 256'(e[199:160]));
      chk("R3 unused slots zero", 256'(f[159:0]), 256'(e[159:0]));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] f;
    int bs, ak;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_write = 0; cmd_index = 0; cmd_wdata = 0; cmd_secondary = 0;
    pcm_valid = 0; pcm_mono = 0; pcm_left = 0; pcm_right = 0;
    pwr_change = 0; sdata_in_pri = 1'b1; sdata_in_sec = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", 256'({sync, sdata_out, ready_pri, ready_sec, cmd_ready}),
        256'(5'b00001));
    rst_n = 1'b1;

    // R11: first frame after reset captures the first tag bit
    wait_start();
    @(negedge clk);
    chk("R11 first capture", 256'({ready_pri, ready_sec}), 256'(2'b10));
    sdata_in_pri = 1'b0; sdata_in_sec = 1'b1;

    // R3: idle frame all zero; R2 sync shape; R11 later frames ignored
    wait_start();
    capture(f, bs, ak);
    chk("R3 idle frame zero", f, '0);
    chk("R2 sync shape idle", 256'(bs), 256'(0));
    chk("R11 later frame ignored", 256'({ready_pri, ready_sec}), 256'(2'b10));

    // R12: power change re-arms, next first bit is captured
    repeat (20) @(negedge clk);
    pwr_change = 1'b1; @(negedge clk); pwr_change = 1'b0;
    wait_start();
    @(negedge clk);
    chk("R12 recapture after power change", 256'({ready_pri, ready_sec}), 256'(2'b01));

    // R11: only the first incoming bit counts
    repeat (20) @(negedge clk);
    pwr_change = 1'b1; @(negedge clk); pwr_change = 1'b0;
    wait_start();
    sdata_in_pri = 1'b1; sdata_in_sec = 1'b0;
    @(negedge clk);
    sdata_in_pri = 1'b0; sdata_in_sec = 1'b1;
    repeat (40) @(negedge clk);
    chk("R11 first bit only", 256'({ready_pri, ready_sec}), 256'(2'b10));

    // Sweep all even register indices
    for (int k = 0; k < 64; k++) begin
      pcm_valid = k[2];
      pcm_mono  = k[3];
      pcm_left  = 20'(k * 4099 + 3);
      pcm_right = 20'(k * 771 + 85);
      run_cmd(k[0], 7'(2 * k), 16'(k * 1031 + 7), k[1]);
    end

    // R8: odd indices refused
    pcm_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      run_cmd(k[0], 7'(16 * k + 2 * k + 1), 16'(k * 97 + 1), k[1]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule